// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Internal Scan and Configuration Paths

This block is a serial test access port driven by a test clock and a mode-select line. A sixteen-state controller walks the standard capture, shift, pause and update sequences for an instruction register and a data register. The loaded instruction decides which data register sits between the serial input and the serial output: a one-bit bypass stage, a built-in identification word, the external boundary register, either of two internal scan rings made of on-chip flip-flops, a serial configuration-write stream, or a memory readback stream. The boundary register, the two scan rings and the configuration memory are outside the block. It drives the capture, shift and update strobes and the path selects that those registers need, and it takes in their serial outputs.

The identification word is built from parameters. From the top bit down it holds a 4-bit revision, a 10-bit array-size field stored with its bits reversed, a 6-bit family code, an 11-bit maker code, and a constant 1 in bit 0. The serial output is registered on the falling test clock edge. It is enabled only while a register is being shifted.

Top module: `scan_access_port`

## Requirements
- R1: A synchronous reset, or five rising test-clock edges with the mode-select line high from any state, puts the controller in its reset state. That state loads the identification instruction (opcode 4'h6 by default), or the bypass opcode 4'hF when the identification word is disabled.
- R2: The controller follows the standard 16-state transition graph. dr_capture, dr_shift and dr_update are high exactly while it is in the Capture-DR, Shift-DR and Update-DR states respectively.
- R3: The 4-bit instruction register loads 4'b0001 in Capture-IR. In Shift-IR it shifts right, with the serial input entering bit 3 and bit 0 driving the serial output. Its value becomes the active instruction in Update-IR.
- R4: With the identification instruction active, Capture-DR loads {revision[3:0], bit-reversed array size[9:0], family[5:0], maker[10:0], 1'b1}. That word then leaves least significant bit first.
- R5: Opcode 4'hF, and any opcode that matches no instruction (for example 4'hA), selects the one-bit bypass stage. It captures 0 and delays the serial input by one shift.
- R6: EXTEST (4'h0) and SAMPLE/PRELOAD (4'h1) both raise sel_boundary and route bscan_so to the serial output. Only EXTEST raises extest_mode.
- R7: Opcodes 4'h2 and 4'h3 raise sel_ring1 or sel_ring2 and route ring1_so or ring2_so to the serial output.
- R8: Opcode 4'h4 raises sel_cfgwr. cfg_wr_strobe is high in every Shift-DR cycle of that instruction, with cfg_wr_data equal to the serial input. The serial output meanwhile carries the bypass stage.
- R9: Opcode 4'h5 raises sel_rdback and routes rdback_so to the serial output.
- R10: tdo and tdo_oe change only on the falling test-clock edge. tdo_oe is high only in the half-cycle that follows the fall of a Shift-DR or Shift-IR cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, falling-edge registered |
| tdo_oe | output | 1 | Output enable for tdo |
| dr_capture | output | 1 | Capture strobe for external data registers |
| dr_shift | output | 1 | Shift strobe for external data registers |
| dr_update | output | 1 | Update strobe for external data registers |
| sel_boundary | output | 1 | Boundary register selected |
| extest_mode | output | 1 | External test instruction active |
| sel_ring1 | output | 1 | First internal scan ring selected |
| sel_ring2 | output | 1 | Second internal scan ring selected |
| sel_cfgwr | output | 1 | Configuration-write path selected |
| sel_rdback | output | 1 | Readback path selected |
| bscan_so | input | 1 | Serial output of the boundary register |
| ring1_so | input | 1 | Serial output of the first scan ring |
| ring2_so | input | 1 | Serial output of the second scan ring |
| rdback_so | input | 1 | Serial readback data from memory |
| cfg_wr_data | output | 1 | Configuration bit presented to the write interface |
| cfg_wr_strobe | output | 1 | Configuration bit valid |

## Verification
The bench forces the five-high escape from the middle of an instruction shift and from Pause-DR. A controller that counted wrongly would leave a non-identification instruction active, and the following data shift would return the wrong word. It reads the identification word serially and compares it against one assembled field by field, so a part field left unreversed or an off-by-one shift shows up as flipped bits. It loads an undefined opcode and checks that bypass data arrives with a one-shift delay after a captured zero. A decoder that left a stale path selected would show ring or boundary data instead. A reference model compares every cycle, including Pause-DR and Exit2-DR detours, so a serial output registered on the rising edge, or enabled outside the shift states, disagrees from the first shifted bit.

// File: rtl/sap_pkg.sv
package sap_pkg;

    localparam int IR_W   = 4;
    localparam int VER_W  = 4;
    localparam int PART_W = 10;
    localparam int FAM_W  = 6;
    localparam int MFR_W  = 11;
    localparam int ID_W   = VER_W + PART_W + FAM_W + MFR_W + 1;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_t;

    typedef enum logic [2:0] {
        PATH_BYPASS, PATH_IDCODE, PATH_BOUNDARY,
        PATH_RING1, PATH_RING2, PATH_CFGWR, PATH_RDBACK
    } path_t;

    typedef struct packed {
        path_t path;
        logic  extest;
    } decode_t;

    function automatic tap_state_t tap_next(input tap_state_t s, input logic tms);
        tap_state_t n;
        case (s)
            TS_RESET:  n = tms ? TS_RESET  : TS_IDLE;
            TS_IDLE:   n = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: n = tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: n = tms ? TS_EX1_DR : TS_SHF_DR;
            TS_SHF_DR: n = tms ? TS_EX1_DR : TS_SHF_DR;
            TS_EX1_DR: n = tms ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: n = tms ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: n = tms ? TS_UPD_DR : TS_SHF_DR;
            TS_UPD_DR: n = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: n = tms ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: n = tms ? TS_EX1_IR : TS_SHF_IR;
            TS_SHF_IR: n = tms ? TS_EX1_IR : TS_SHF_IR;
            TS_EX1_IR: n = tms ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: n = tms ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: n = tms ? TS_UPD_IR : TS_SHF_IR;
            TS_UPD_IR: n = tms ? TS_SEL_DR : TS_IDLE;
            default:   n = TS_RESET;
        endcase
        return n;
    endfunction

    function automatic logic [PART_W-1:0] bit_reverse(input logic [PART_W-1:0] v);
        logic [PART_W-1:0] r;
        for (int i = 0; i < PART_W; i++) r[i] = v[PART_W-1-i];
        return r;
    endfunction

    function automatic logic [ID_W-1:0] build_idword(
        input logic [VER_W-1:0]  ver,
        input logic [PART_W-1:0] size,
        input logic [FAM_W-1:0]  fam,
        input logic [MFR_W-1:0]  mfr
    );
        return {ver, bit_reverse(size), fam, mfr, 1'b1};
    endfunction

endpackage

// File: rtl/sap_fsm.sv
module sap_fsm
    import sap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_t state
);

    always_ff @(posedge tck) begin
        if (rst) state <= TS_RESET;
        else     state <= tap_next(state, tms);
    end

    // run length of consecutive high mode-select samples, saturating at five
    logic [2:0] ones_run;
    always_ff @(posedge tck) begin
        if (rst)                    ones_run <= 3'd0;
        else if (!tms)              ones_run <= 3'd0;
        else if (ones_run != 3'd5)  ones_run <= ones_run + 3'd1;
    end

    p_five_ones_reset_r1: assert property (@(posedge tck) disable iff (rst)
        (ones_run == 3'd5) |-> (state == TS_RESET));

    p_update_from_exit_r2: assert property (@(posedge tck) disable iff (rst)
        (state == TS_UPD_DR) |-> ($past(state) == TS_EX1_DR || $past(state) == TS_EX2_DR));

endmodule

// File: rtl/sap_ireg.sv
module sap_ireg
    import sap_pkg::*;
#(
    parameter logic [IR_W-1:0] OP_EXTEST = 4'h0,
    parameter logic [IR_W-1:0] OP_SAMPLE = 4'h1,
    parameter logic [IR_W-1:0] OP_RING1  = 4'h2,
    parameter logic [IR_W-1:0] OP_RING2  = 4'h3,
    parameter logic [IR_W-1:0] OP_CFGWR  = 4'h4,
    parameter logic [IR_W-1:0] OP_RDBACK = 4'h5,
    parameter logic [IR_W-1:0] OP_IDCODE = 4'h6,
    parameter bit              IDCODE_EN = 1'b1
) (
    input  logic       tck,
    input  logic       rst,
    input  logic       tdi,
    input  tap_state_t state,
    output logic       ir_lsb,
    output decode_t    dec
);

    localparam logic [IR_W-1:0] OP_BYPASS   = '1;
    localparam logic [IR_W-1:0] RESET_OP    = IDCODE_EN ? OP_IDCODE : OP_BYPASS;
    localparam logic [IR_W-1:0] CAPTURE_PAT = {{(IR_W-1){1'b0}}, 1'b1};

    logic [IR_W-1:0] ir_sr;
    logic [IR_W-1:0] instr;

    always_ff @(posedge tck) begin
        if (rst) begin
            ir_sr <= CAPTURE_PAT;
            instr <= RESET_OP;
        end else begin
            case (state)
                TS_CAP_IR: ir_sr <= CAPTURE_PAT;
                TS_SHF_IR: ir_sr <= {tdi, ir_sr[IR_W-1:1]};
                default:   ir_sr <= ir_sr;
            endcase
            if (state == TS_RESET)       instr <= RESET_OP;
            else if (state == TS_UPD_IR) instr <= ir_sr;
        end
    end

    assign ir_lsb = ir_sr[0];

    always_comb begin
        dec.path   = PATH_BYPASS;
        dec.extest = 1'b0;
        if (instr == OP_EXTEST) begin
            dec.path   = PATH_BOUNDARY;
            dec.extest = 1'b1;
        end else if (instr == OP_SAMPLE)              dec.path = PATH_BOUNDARY;
        else if (instr == OP_RING1)                   dec.path = PATH_RING1;
        else if (instr == OP_RING2)                   dec.path = PATH_RING2;
        else if (instr == OP_CFGWR)                   dec.path = PATH_CFGWR;
        else if (instr == OP_RDBACK)                  dec.path = PATH_RDBACK;
        else if (IDCODE_EN && instr == OP_IDCODE)     dec.path = PATH_IDCODE;
    end

    p_tlr_loads_default_r1: assert property (@(posedge tck) disable iff (rst)
        (state == TS_RESET) |=> (instr == RESET_OP));

    p_capture_ir_r3: assert property (@(posedge tck) disable iff (rst)
        (state == TS_CAP_IR) |=> (ir_sr == CAPTURE_PAT));

    p_update_ir_r3: assert property (@(posedge tck) disable iff (rst)
        (state == TS_UPD_IR) |=> (instr == $past(ir_sr)));

endmodule

// File: rtl/sap_dregs.sv
module sap_dregs
    import sap_pkg::*;
#(
    parameter logic [ID_W-1:0] IDWORD = '1
) (
    input  logic       tck,
    input  logic       rst,
    input  logic       tdi,
    input  tap_state_t state,
    input  decode_t    dec,
    output logic       byp_q,
    output logic       id_lsb
);

    logic [ID_W-1:0] id_sr;
    logic            id_sel;

    assign id_sel = (dec.path == PATH_IDCODE);

    always_ff @(posedge tck) begin
        if (rst) begin
            byp_q <= 1'b0;
            id_sr <= '0;
        end else begin
            if (state == TS_CAP_DR)      byp_q <= 1'b0;
            else if (state == TS_SHF_DR) byp_q <= tdi;

            if (id_sel && state == TS_CAP_DR)      id_sr <= IDWORD;
            else if (id_sel && state == TS_SHF_DR) id_sr <= {tdi, id_sr[ID_W-1:1]};
        end
    end

    assign id_lsb = id_sr[0];

    p_id_capture_r4: assert property (@(posedge tck) disable iff (rst)
        (state == TS_CAP_DR && id_sel) |=> (id_lsb == 1'b1));

    p_bypass_capture_r5: assert property (@(posedge tck) disable iff (rst)
        (state == TS_CAP_DR) |=> (byp_q == 1'b0));

    p_bypass_shift_r5: assert property (@(posedge tck) disable iff (rst)
        (state == TS_SHF_DR) |=> (byp_q == $past(tdi)));

endmodule

// File: rtl/sap_tdo.sv
module sap_tdo
    import sap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  tap_state_t state,
    input  decode_t    dec,
    input  logic       ir_lsb,
    input  logic       byp_q,
    input  logic       id_lsb,
    input  logic       bscan_so,
    input  logic       ring1_so,
    input  logic       ring2_so,
    input  logic       rdback_so,
    output logic       tdo,
    output logic       tdo_oe
);

    logic serial;
    logic shifting;

    assign shifting = (state == TS_SHF_DR) || (state == TS_SHF_IR);

    always_comb begin
        if (state == TS_SHF_IR) serial = ir_lsb;
        else begin
            case (dec.path)
                PATH_IDCODE:   serial = id_lsb;
                PATH_BOUNDARY: serial = bscan_so;
                PATH_RING1:    serial = ring1_so;
                PATH_RING2:    serial = ring2_so;
                PATH_RDBACK:   serial = rdback_so;
                default:       serial = byp_q;
            endcase
        end
    end

    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= serial;
            tdo_oe <= shifting;
        end
    end

    p_oe_in_shift_r10: assert property (@(posedge tck) disable iff (rst)
        tdo_oe |-> shifting);

endmodule

// File: rtl/scan_access_port.sv
module scan_access_port
    import sap_pkg::*;
#(
    parameter logic [IR_W-1:0]   OP_EXTEST = 4'h0,
    parameter logic [IR_W-1:0]   OP_SAMPLE = 4'h1,
    parameter logic [IR_W-1:0]   OP_RING1  = 4'h2,
    parameter logic [IR_W-1:0]   OP_RING2  = 4'h3,
    parameter logic [IR_W-1:0]   OP_CFGWR  = 4'h4,
    parameter logic [IR_W-1:0]   OP_RDBACK = 4'h5,
    parameter logic [IR_W-1:0]   OP_IDCODE = 4'h6,
    parameter bit                IDCODE_EN = 1'b1,
    parameter logic [VER_W-1:0]  ID_VER    = 4'h3,
    parameter logic [PART_W-1:0] ID_SIZE   = 10'd20,
    parameter logic [FAM_W-1:0]  ID_FAM    = 6'h13,
    parameter logic [MFR_W-1:0]  ID_MFR    = 11'h2A5
) (
    input  logic tck,
    input  logic rst,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_oe,
    output logic dr_capture,
    output logic dr_shift,
    output logic dr_update,
    output logic sel_boundary,
    output logic extest_mode,
    output logic sel_ring1,
    output logic sel_ring2,
    output logic sel_cfgwr,
    output logic sel_rdback,
    input  logic bscan_so,
    input  logic ring1_so,
    input  logic ring2_so,
    input  logic rdback_so,
    output logic cfg_wr_data,
    output logic cfg_wr_strobe
);

    localparam logic [ID_W-1:0] IDWORD = build_idword(ID_VER, ID_SIZE, ID_FAM, ID_MFR);

    tap_state_t state;
    decode_t    dec;
    logic       ir_lsb, byp_q, id_lsb;

    sap_fsm u_fsm (.tck(tck), .rst(rst), .tms(tms), .state(state));

    sap_ireg #(
        .OP_EXTEST(OP_EXTEST), .OP_SAMPLE(OP_SAMPLE), .OP_RING1(OP_RING1),
        .OP_RING2(OP_RING2),   .OP_CFGWR(OP_CFGWR),   .OP_RDBACK(OP_RDBACK),
        .OP_IDCODE(OP_IDCODE), .IDCODE_EN(IDCODE_EN)
    ) u_ireg (
        .tck(tck), .rst(rst), .tdi(tdi), .state(state), .ir_lsb(ir_lsb), .dec(dec)
    );

    sap_dregs #(.IDWORD(IDWORD)) u_dregs (
        .tck(tck), .rst(rst), .tdi(tdi), .state(state), .dec(dec),
        .byp_q(byp_q), .id_lsb(id_lsb)
    );

    sap_tdo u_tdo (
        .tck(tck), .rst(rst), .state(state), .dec(dec), .ir_lsb(ir_lsb),
        .byp_q(byp_q), .id_lsb(id_lsb), .bscan_so(bscan_so), .ring1_so(ring1_so),
        .ring2_so(ring2_so), .rdback_so(rdback_so), .tdo(tdo), .tdo_oe(tdo_oe)
    );

    assign dr_capture    = (state == TS_CAP_DR);
    assign dr_shift      = (state == TS_SHF_DR);
    assign dr_update     = (state == TS_UPD_DR);
    assign sel_boundary  = (dec.path == PATH_BOUNDARY);
    assign extest_mode   = dec.extest;
    assign sel_ring1     = (dec.path == PATH_RING1);
    assign sel_ring2     = (dec.path == PATH_RING2);
    assign sel_cfgwr     = (dec.path == PATH_CFGWR);
    assign sel_rdback    = (dec.path == PATH_RDBACK);
    assign cfg_wr_data   = tdi;
    assign cfg_wr_strobe = dr_shift && sel_cfgwr;

endmodule

// File: tb/scan_access_port_test.sv
module scan_access_port_test;

    localparam int RESET = 0, IDLE = 1, SELDR = 2, CAPDR = 3, SHFDR = 4, EX1DR = 5,
                   PAUDR = 6, EX2DR = 7, UPDDR = 8, SELIR = 9, CAPIR = 10, SHFIR = 11,
                   EX1IR = 12, PAUIR = 13, EX2IR = 14, UPDIR = 15;
    localparam logic [3:0] VER = 4'h3;
    localparam logic [9:0] SIZE = 10'd20;
    localparam logic [5:0] FAM = 6'h13;
    localparam logic [10:0] MFR = 11'h2A5;

    logic tck = 1'b0, rst = 1'b1, tms = 1'b1, tdi = 1'b0;
    logic bscan_so = 1'b0, ring1_so = 1'b0, ring2_so = 1'b0, rdback_so = 1'b0;
    logic tdo, tdo_oe, dr_capture, dr_shift, dr_update, sel_boundary, extest_mode;
    logic sel_ring1, sel_ring2, sel_cfgwr, sel_rdback, cfg_wr_data, cfg_wr_strobe;
    logic nb_tdo, nb_oe, nb_c, nb_s, nb_u, nb_b, nb_x, nb_r1, nb_r2, nb_cw, nb_rb, nb_d, nb_st;

    always #5 tck = ~tck;

    scan_access_port #(.ID_VER(VER), .ID_SIZE(SIZE), .ID_FAM(FAM), .ID_MFR(MFR)) uut (
        .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
        .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
        .sel_boundary(sel_boundary), .extest_mode(extest_mode), .sel_ring1(sel_ring1),
        .sel_ring2(sel_ring2), .sel_cfgwr(sel_cfgwr), .sel_rdback(sel_rdback),
        .bscan_so(bscan_so), .ring1_so(ring1_so), .ring2_so(ring2_so), .rdback_so(rdback_so),
        .cfg_wr_data(cfg_wr_data), .cfg_wr_strobe(cfg_wr_strobe));

    scan_access_port #(.IDCODE_EN(1'b0)) uut_nb (
        .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .tdo(nb_tdo), .tdo_oe(nb_oe),
        .dr_capture(nb_c), .dr_shift(nb_s), .dr_update(nb_u),
        .sel_boundary(nb_b), .extest_mode(nb_x), .sel_ring1(nb_r1),
        .sel_ring2(nb_r2), .sel_cfgwr(nb_cw), .sel_rdback(nb_rb),
        .bscan_so(bscan_so), .ring1_so(ring1_so), .ring2_so(ring2_so), .rdback_so(rdback_so),
        .cfg_wr_data(nb_d), .cfg_wr_strobe(nb_st));

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int st = RESET;
    logic [3:0] m_ir = 4'b0001, m_instr = 4'h6;
    bit id_q[$];
    logic m_byp = 1'b0;
    logic [31:0] lfsr = 32'hACE1_2469;
    logic obs_tdo, obs_nb;

    function automatic int nxt(input int s, input logic t);
        case (s)
            RESET: return t ? RESET : IDLE;
            IDLE:  return t ? SELDR : IDLE;
            SELDR: return t ? SELIR : CAPDR;
            CAPDR, SHFDR: return t ? EX1DR : SHFDR;
            EX1DR: return t ? UPDDR : PAUDR;
            PAUDR: return t ? EX2DR : PAUDR;
            EX2DR: return t ? UPDDR : SHFDR;
            SELIR: return t ? RESET : CAPIR;
            CAPIR, SHFIR: return t ? EX1IR : SHFIR;
            EX1IR: return t ? UPDIR : PAUIR;
            PAUIR: return t ? EX2IR : PAUIR;
            EX2IR: return t ? UPDIR : SHFIR;
            default: return t ? SELDR : IDLE;
        endcase
    endfunction

    function automatic logic [31:0] exp_id();
        logic [9:0] r;
        for (int i = 0; i < 10; i++) r[9-i] = SIZE[i];
        return {VER, r, FAM, MFR, 1'b1};
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_word(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic tms_v, input logic tdi_v);
        logic e_tdo;
        string tg;
        bit is_bnd;
        tms = tms_v; tdi = tdi_v;
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        bscan_so = lfsr[3]; ring1_so = lfsr[9]; ring2_so = lfsr[17]; rdback_so = lfsr[26];
        #8;
        obs_tdo = tdo; obs_nb = nb_tdo;
        is_bnd = (m_instr == 4'h0 || m_instr == 4'h1);
        chk(dr_capture, st == CAPDR, "R2 dr_capture");
        chk(dr_shift, st == SHFDR, "R2 dr_shift");
        chk(dr_update, st == UPDDR, "R2 dr_update");
        chk(sel_boundary, is_bnd, "R6 sel_boundary");
        chk(extest_mode, m_instr == 4'h0, "R6 extest_mode");
        chk(sel_ring1, m_instr == 4'h2, "R7 sel_ring1");
        chk(sel_ring2, m_instr == 4'h3, "R7 sel_ring2");
        chk(sel_cfgwr, m_instr == 4'h4, "R8 sel_cfgwr");
        chk(sel_rdback, m_instr == 4'h5, "R9 sel_rdback");
        chk(cfg_wr_strobe, st == SHFDR && m_instr == 4'h4, "R8 cfg_wr_strobe");
        if (cfg_wr_strobe) chk(cfg_wr_data, tdi, "R8 cfg_wr_data");
        chk(tdo_oe, st == SHFDR || st == SHFIR, "R10 tdo_oe");
        if (st == SHFIR) begin e_tdo = m_ir[0]; tg = "R3 tdo"; end
        else if (is_bnd) begin e_tdo = bscan_so; tg = "R6 tdo"; end
        else if (m_instr == 4'h2) begin e_tdo = ring1_so; tg = "R7 tdo"; end
        else if (m_instr == 4'h3) begin e_tdo = ring2_so; tg = "R7 tdo"; end
        else if (m_instr == 4'h5) begin e_tdo = rdback_so; tg = "R9 tdo"; end
        else if (m_instr == 4'h6) begin e_tdo = id_q[0]; tg = "R4 tdo"; end
        else if (m_instr == 4'h4) begin e_tdo = m_byp; tg = "R8 tdo"; end
        else begin e_tdo = m_byp; tg = "R5 tdo"; end
        if (st == SHFDR || st == SHFIR) chk(tdo, e_tdo, tg);
        // reference update at the rising edge
        case (st)
            RESET: m_instr = 4'h6;
            CAPIR: m_ir = 4'b0001;
            SHFIR: m_ir = {tdi, m_ir[3:1]};
            UPDIR: m_instr = m_ir;
            CAPDR: begin
                m_byp = 1'b0;
                if (m_instr == 4'h6) begin
                    logic [31:0] w;
                    w = exp_id();
                    id_q.delete();
                    for (int i = 0; i < 32; i++) id_q.push_back(w[i]);
                end
            end
            SHFDR: begin
                m_byp = tdi;
                if (m_instr == 4'h6) begin void'(id_q.pop_front()); id_q.push_back(tdi); end
            end
            default: ;
        endcase
        st = nxt(st, tms_v);
        @(posedge tck); #1;
    endtask

    task automatic load_ir(input logic [3:0] op, output logic [3:0] seen);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 4; i++) begin tick(i == 3, op[i]); seen[i] = obs_tdo; end
        tick(1, 0); tick(0, 0);
    endtask

    task automatic shift_dr(input int n, input logic [63:0] din,
                            output logic [63:0] dout, output logic [63:0] dnb);
        dout = '0; dnb = '0;
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, din[i]); dout[i] = obs_tdo; dnb[i] = obs_nb;
        end
        tick(1, 0); tick(0, 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] d, o, onb, e;
        logic [3:0] seen;
        repeat (3) @(posedge tck);
        #1; rst = 0;
        // R1: reset state, strobes idle, output disabled
        tick(1, 0);
        tick(0, 0);
        // R1 R4: identification word read after reset
        d = 64'h0000_0000_9249_2492;
        shift_dr(32, d, o, onb);
        chk_word(o[31:0], exp_id(), "R4 idcode word after reset R1");
        // R1 R5: variant without identification word shows bypass
        e = '0;
        for (int i = 1; i < 32; i++) e[i] = d[i-1];
        chk_word(onb[31:0], e[31:0], "R1 bypass default when id disabled");
        // R3: captured instruction pattern leaves LSB first
        load_ir(4'hA, seen);
        chk_word({60'd0, seen}, 64'h1, "R3 ir capture pattern");
        // R5: unrecognised opcode acts as bypass
        d = 64'h0000_0000_0000_00B5;
        shift_dr(8, d, o, onb);
        chk_word(o[7:0], {d[6:0], 1'b0}, "R5 undefined opcode bypass");
        load_ir(4'hF, seen);
        d = 64'h0000_0000_0000_3C69;
        shift_dr(16, d, o, onb);
        chk_word(o[15:0], {d[14:0], 1'b0}, "R5 bypass opcode delay");
        // R6 R7 R8 R9: each path exercised by the per-cycle model
        load_ir(4'h0, seen); shift_dr(12, 64'h5A3, o, onb);
        load_ir(4'h1, seen); shift_dr(12, 64'hC71, o, onb);
        load_ir(4'h2, seen); shift_dr(20, 64'h9F0E1, o, onb);
        load_ir(4'h3, seen); shift_dr(20, 64'h3B6D4, o, onb);
        load_ir(4'h4, seen); shift_dr(24, 64'hD1E2F3, o, onb);
        chk_word(o[23:0], {24'hD1E2F3 << 1} & 24'hFFFFFF, "R8 cfg path tdo carries bypass");
        load_ir(4'h5, seen); shift_dr(16, 64'h7E81, o, onb);
        // R2: pause and exit2 detour inside a data shift
        load_ir(4'h2, seen);
        tick(1, 0); tick(0, 0); tick(0, 0);
        tick(0, 1); tick(1, 0);
        tick(0, 0); tick(0, 0); tick(1, 0); tick(0, 1);
        tick(0, 1); tick(1, 1); tick(1, 0); tick(0, 0);
        // R1: five highs from the middle of an instruction shift
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0); tick(0, 1);
        repeat (5) tick(1, 0);
        tick(0, 0);
        shift_dr(32, 64'h0, o, onb);
        chk_word(o[31:0], exp_id(), "R1 escape from Shift-IR");
        // R1: five highs from Pause-DR under another instruction
        load_ir(4'h3, seen);
        tick(1, 0); tick(0, 0); tick(1, 0); tick(0, 0);
        repeat (5) tick(1, 0);
        tick(0, 0);
        shift_dr(32, 64'hFFFF_FFFF, o, onb);
        chk_word(o[31:0], exp_id(), "R1 escape from Pause-DR");
        // R10: output disabled again in idle
        tick(0, 0);
        chk(tdo_oe, 1'b0, "R10 idle disables tdo");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule